// File: doc/BRIEF.md
# Tabular Q-Learning Update Engine

This block holds a reinforcement-learning quality table of N_STATES rows by N_ACTIONS columns in signed fixed point. It updates the table as samples stream in, one entry per clock. A sample is a state index, an action index and a reward, qualified by `valid_i`. The block holds each sample in registers until the next valid sample arrives. The next sample then supplies the successor state, so the block can build the learning target and rewrite the table entry for the held state and action.

The table is split into one column store per action. All column stores are read at the incoming state, which yields the row for that state. The same row goes out on `row_o`, and its signed maximum goes out on `qmax_o`, so that an external policy generator can choose actions. Each write goes to exactly one column, picked by a one-hot decode of the held action. In learning mode the target is the row maximum. When `sarsa_i` is high, the target is the row entry for the incoming action instead. Learning rate and discount factor are unsigned fractions that are applied each cycle.

Top module: `qlearn_engine`

## Requirements
- R1: After the asynchronous reset, `row_o` is zero for every `state_i`.
- R2: `row_o` gives the stored row for `state_i` with no clock delay. Column a sits in bits [a*Q_W +: Q_W]. The row shows every write made at earlier edges, and it does not show the write made at the coming edge.
- R3: `qmax_o` equals the largest of the N_ACTIONS signed entries of `row_o`.
- R4: Let sample k be (s,a,r), and let sample k+1 be the next valid sample, with state s' and action a'. At the clock edge that takes sample k+1, entry (s,a) is rewritten from its old value q. The steps are:
  - t is the maximum of row s' as it stands before that edge.
  - b = sat(r + floor(t*gamma_i / 2^FRAC_W)).
  - d = sat(b - q).
  - The new value is sat(q + floor(d*alpha_i / 2^FRAC_W)).
  - alpha_i and gamma_i are unsigned, with value equal to code/2^FRAC_W, so a code of 2^FRAC_W means 1.0.
- R5: When `sarsa_i` is high in the cycle that sample k+1 arrives, t is entry (s',a') of the row instead of the maximum.
- R6: Each of the three sums in R4 clamps to the range from -2^(Q_W-1) to 2^(Q_W-1)-1 instead of wrapping.
- R7: When consecutive valid samples share a state, the later update uses the value just written by the earlier one. The results then match a strictly sequential application of R4 or R5.
- R8: A cycle with `valid_i` low writes nothing and keeps the held sample. The next valid sample updates that held sample.
- R9: `clear_i` takes priority over `valid_i`. It zeroes every entry at the next edge and discards any held sample, so the first valid sample after a clear writes nothing.
- R10: A valid cycle changes at most one table entry, the one for the held state and action. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Synchronous zeroing of the whole table |
| valid_i | input | 1 | Sample qualifier; enables the write and the advance of the held sample |
| sarsa_i | input | 1 | 1: target is the entry for the incoming action; 0: target is the row maximum |
| state_i | input | $clog2(N_STATES) | Incoming state; read address of all column stores |
| action_i | input | $clog2(N_ACTIONS) | Incoming action |
| reward_i | input | Q_W | Signed reward belonging to the incoming sample |
| alpha_i | input | FRAC_W+1 | Learning rate, unsigned, FRAC_W fraction bits |
| gamma_i | input | FRAC_W+1 | Discount factor, unsigned, FRAC_W fraction bits |
| row_o | output | N_ACTIONS*Q_W | Stored row for state_i |
| qmax_o | output | Q_W | Signed maximum of row_o |

## Verification
The case to watch is a write-back and a row read that fall on the same state in the same cycle. The row read for the target must see the old value, and the held copy of that row must take the new value. The bench provokes this with long runs of a single state and action, and with runs that stay in one state but change the action. Repeated runs of this kind only keep matching the bench's sequential arithmetic model if the forwarding is correct. A clear that lands in the same cycle as a valid sample is also driven. After it, a full-table sweep must read zero, and the bench checks that the following sample writes nothing.

// File: rtl/qle_pkg.sv
package qle_pkg;
  typedef enum logic {
    TGT_ROW_MAX  = 1'b0,
    TGT_NEXT_ACT = 1'b1
  } tgt_sel_e;
endpackage

// File: rtl/qle_max_tree.sv
module qle_max_tree #(
  parameter int N_IN = 4,
  parameter int W    = 16
) (
  input  logic [N_IN-1:0][W-1:0] row_i,
  output logic [W-1:0]           max_o
);
  localparam int LV = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int P  = 1 << LV;
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] node [1:2*P-1];

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N_IN) begin : g_used
      assign node[P+i] = row_i[i];
    end else begin : g_pad
      assign node[P+i] = MIN_V;
    end
  end

  for (genvar k = 1; k < P; k++) begin : g_cmp
    assign node[k] = (node[2*k] > node[2*k+1]) ? node[2*k] : node[2*k+1];
  end

  assign max_o = node[1];
endmodule

// File: rtl/qle_table.sv
module qle_table #(
  parameter int N_STATES  = 8,
  parameter int N_ACTIONS = 4,
  parameter int W         = 16,
  localparam int SW = (N_STATES > 1) ? $clog2(N_STATES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic [N_ACTIONS-1:0]       we_i,
  input  logic [SW-1:0]              waddr_i,
  input  logic [W-1:0]               wdata_i,
  input  logic [SW-1:0]              raddr_i,
  output logic [N_ACTIONS-1:0][W-1:0] rdata_o
);
  for (genvar g = 0; g < N_ACTIONS; g++) begin : g_col
    logic [W-1:0] col [N_STATES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int j = 0; j < N_STATES; j++) col[j] <= '0;
      end else if (clear_i) begin
        for (int j = 0; j < N_STATES; j++) col[j] <= '0;
      end else if (we_i[g]) begin
        col[waddr_i] <= wdata_i;
      end
    end

    assign rdata_o[g] = col[raddr_i];
  end
endmodule

// File: rtl/qle_updater.sv
module qle_updater #(
  parameter int W      = 16,
  parameter int FRAC_W = 8
) (
  input  logic signed [W-1:0] q_i,
  input  logic signed [W-1:0] target_i,
  input  logic signed [W-1:0] reward_i,
  input  logic [FRAC_W:0]     alpha_i,
  input  logic [FRAC_W:0]     gamma_i,
  output logic signed [W-1:0] q_o
);
  localparam int PW = W + FRAC_W + 2;
  localparam logic signed [PW-1:0] HI = PW'((64'sd1 <<< (W-1)) - 64'sd1);
  localparam logic signed [PW-1:0] LO = -HI - PW'(1);

  function automatic logic signed [W-1:0] sat(input logic signed [PW-1:0] v);
    if (v > HI)      return W'(HI);
    else if (v < LO) return W'(LO);
    else             return W'(v);
  endfunction

  logic signed [PW-1:0] g_prod, g_term, bell_w, diff_w, a_prod, a_term, nq_w;
  logic signed [W-1:0]  bell, diff;

  always_comb begin
    g_prod = PW'(target_i) * $signed({{(PW-FRAC_W-1){1'b0}}, gamma_i});
    g_term = g_prod >>> FRAC_W;
    bell_w = g_term + PW'(reward_i);
    bell   = sat(bell_w);
    diff_w = PW'(bell) - PW'(q_i);
    diff   = sat(diff_w);
    a_prod = PW'(diff) * $signed({{(PW-FRAC_W-1){1'b0}}, alpha_i});
    a_term = a_prod >>> FRAC_W;
    nq_w   = a_term + PW'(q_i);
    q_o    = sat(nq_w);
  end
endmodule

// File: rtl/qlearn_engine.sv
module qlearn_engine
  import qle_pkg::*;
#(
  parameter int N_STATES  = 8,
  parameter int N_ACTIONS = 4,
  parameter int Q_W       = 16,
  parameter int FRAC_W    = 8,
  localparam int SW = (N_STATES > 1) ? $clog2(N_STATES) : 1,
  localparam int AW = (N_ACTIONS > 1) ? $clog2(N_ACTIONS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     valid_i,
  input  logic                     sarsa_i,
  input  logic [SW-1:0]            state_i,
  input  logic [AW-1:0]            action_i,
  input  logic signed [Q_W-1:0]    reward_i,
  input  logic [FRAC_W:0]          alpha_i,
  input  logic [FRAC_W:0]          gamma_i,
  output logic [N_ACTIONS*Q_W-1:0] row_o,
  output logic [Q_W-1:0]           qmax_o
);
  logic [N_ACTIONS-1:0][Q_W-1:0] row_raw, row_fwd, row_q;
  logic [SW-1:0]                 s_t;
  logic [AW-1:0]                 a_t;
  logic signed [Q_W-1:0]         r_t;
  logic                          have_prev;
  logic                          write_en;
  logic [N_ACTIONS-1:0]          we_vec;
  logic signed [Q_W-1:0]         row_max, target, q_cur, q_new;
  tgt_sel_e                      tsel;

  qle_table #(
    .N_STATES (N_STATES),
    .N_ACTIONS(N_ACTIONS),
    .W        (Q_W)
  ) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .we_i   (we_vec),
    .waddr_i(s_t),
    .wdata_i(q_new),
    .raddr_i(state_i),
    .rdata_o(row_raw)
  );

  qle_max_tree #(
    .N_IN(N_ACTIONS),
    .W   (Q_W)
  ) u_max (
    .row_i(row_raw),
    .max_o(row_max)
  );

  assign tsel   = tgt_sel_e'(sarsa_i);
  assign target = (tsel == TGT_NEXT_ACT) ? row_raw[action_i] : row_max;
  assign q_cur  = row_q[a_t];

  qle_updater #(
    .W     (Q_W),
    .FRAC_W(FRAC_W)
  ) u_upd (
    .q_i     (q_cur),
    .target_i(target),
    .reward_i(r_t),
    .alpha_i (alpha_i),
    .gamma_i (gamma_i),
    .q_o     (q_new)
  );

  assign write_en = valid_i && have_prev && !clear_i;

  always_comb begin
    we_vec = '0;
    if (write_en) we_vec[a_t] = 1'b1;
  end

  // held row must see the entry written at this edge
  always_comb begin
    row_fwd = row_raw;
    if (write_en && (state_i == s_t)) row_fwd[a_t] = q_new;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_t       <= '0;
      a_t       <= '0;
      r_t       <= '0;
      row_q     <= '0;
      have_prev <= 1'b0;
    end else if (clear_i) begin
      s_t       <= '0;
      a_t       <= '0;
      r_t       <= '0;
      row_q     <= '0;
      have_prev <= 1'b0;
    end else if (valid_i) begin
      s_t       <= state_i;
      a_t       <= action_i;
      r_t       <= reward_i;
      row_q     <= row_fwd;
      have_prev <= 1'b1;
    end
  end

  assign row_o  = row_raw;
  assign qmax_o = row_max;
endmodule

// File: rtl/qle_checker.sv
module qle_checker #(
  parameter int N_ACTIONS = 4,
  parameter int Q_W       = 16,
  parameter int SW        = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     clear_i,
  input logic                     valid_i,
  input logic [SW-1:0]            state_i,
  input logic [N_ACTIONS*Q_W-1:0] row_o,
  input logic [Q_W-1:0]           qmax_o,
  input logic [N_ACTIONS-1:0]     we_i
);
  logic all_le, any_eq;

  always_comb begin
    all_le = 1'b1;
    any_eq = 1'b0;
    for (int k = 0; k < N_ACTIONS; k++) begin
      if ($signed(row_o[k*Q_W +: Q_W]) > $signed(qmax_o)) all_le = 1'b0;
      if (row_o[k*Q_W +: Q_W] == qmax_o) any_eq = 1'b1;
    end
  end

  p_max_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) all_le);
  p_max_member_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) any_eq);
  p_single_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(we_i));
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i) |=> (!$stable(state_i) || $stable(row_o)));
  p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (row_o == '0));
endmodule

bind qlearn_engine qle_checker #(
  .N_ACTIONS(N_ACTIONS),
  .Q_W      (Q_W),
  .SW       (SW)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clear_i(clear_i),
  .valid_i(valid_i),
  .state_i(state_i),
  .row_o  (row_o),
  .qmax_o (qmax_o),
  .we_i   (we_vec)
);

// File: tb/sim_qlearn_engine.sv
`timescale 1ns/1ps
module sim_qlearn_engine;
  localparam int N = 8;
  localparam int Z = 4;
  localparam int W = 16;
  localparam int F = 8;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           clear_i = 1'b0;
  logic           valid_i = 1'b0;
  logic           sarsa_i = 1'b0;
  logic [2:0]     state_i = '0;
  logic [1:0]     action_i = '0;
  logic [W-1:0]   reward_i = '0;
  logic [F:0]     alpha_i = '0;
  logic [F:0]     gamma_i = '0;
  logic [Z*W-1:0] row_o;
  logic [W-1:0]   qmax_o;

  qlearn_engine #(.N_STATES(N), .N_ACTIONS(Z), .Q_W(W), .FRAC_W(F)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .valid_i(valid_i),
    .sarsa_i(sarsa_i), .state_i(state_i), .action_i(action_i),
    .reward_i(reward_i), .alpha_i(alpha_i), .gamma_i(gamma_i),
    .row_o(row_o), .qmax_o(qmax_o)
  );

  always #2.5 clk = ~clk;

  longint      model [N][Z];
  int          ps, pa;
  longint      pr;
  bit          hp;
  int          total = 0, bad = 0;
  bit          done = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  function automatic longint sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint upd(longint q, longint t, longint r, longint al, longint ga);
    longint b, d;
    b = sat(r + ((t * ga) >>> F));
    d = sat(b - q);
    return sat(q + ((d * al) >>> F));
  endfunction

  function automatic longint rowmax(int s);
    longint m = model[s][0];
    for (int k = 1; k < Z; k++) if (model[s][k] > m) m = model[s][k];
    return m;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int s, int a, longint r, bit v, bit sar, string tag);
    longint t;
    @(negedge clk);
    state_i = 3'(s); action_i = 2'(a); reward_i = W'(r); valid_i = v; sarsa_i = sar;
    #1;
    for (int k = 0; k < Z; k++)
      chk($sformatf("%s row s=%0d a=%0d", tag, s, k),
          longint'($signed(row_o[k*W +: W])), model[s][k]);
    chk($sformatf("R3 qmax s=%0d", s), longint'($signed(qmax_o)), rowmax(s));
    if (v) begin
      if (hp) begin
        t = sar ? model[s][a] : rowmax(s);
        model[ps][pa] = upd(model[ps][pa], t, pr, longint'(alpha_i), longint'(gamma_i));
      end
      ps = s; pa = a; pr = r; hp = 1;
    end
    @(posedge clk);
  endtask

  task automatic sweep(string tag);
    for (int s = 0; s < N; s++) step(s, 0, 0, 0, 0, tag);
  endtask

  task automatic do_clear(bit with_valid);
    @(negedge clk);
    clear_i = 1'b1; valid_i = with_valid; state_i = 3'd5; action_i = 2'd2; reward_i = W'(99);
    @(posedge clk);
    @(negedge clk);
    clear_i = 1'b0; valid_i = 1'b0;
    for (int s = 0; s < N; s++) for (int k = 0; k < Z; k++) model[s][k] = 0;
    hp = 0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(200000.0 * 5.0);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < N; s++) for (int k = 0; k < Z; k++) model[s][k] = 0;
    hp = 0; ps = 0; pa = 0; pr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    sweep("R1");

    // R4: learning mode, mixed rewards
    alpha_i = 9'd128; gamma_i = 9'd230;
    for (int i = 0; i < 200; i++)
      step(rnd() % N, rnd() % Z, longint'(rnd() % 601) - 300, 1, 0, "R4");
    sweep("R4");

    // R5: next-action target
    alpha_i = 9'd77; gamma_i = 9'd200;
    for (int i = 0; i < 200; i++)
      step(rnd() % N, rnd() % Z, longint'(rnd() % 801) - 400, 1, 1, "R5");
    sweep("R5");

    // R7: back-to-back same state, same and changing action
    alpha_i = 9'd100; gamma_i = 9'd180;
    for (int i = 0; i < 20; i++) step(3, 1, 50, 1, 0, "R7");
    for (int i = 0; i < 20; i++) step(6, i % Z, 120 - 10 * i, 1, i % 2, "R7");
    sweep("R7");

    // R6: full-scale coefficients and extreme rewards
    alpha_i = 9'd256; gamma_i = 9'd256;
    for (int i = 0; i < 60; i++)
      step(rnd() % N, rnd() % Z, (rnd() % 2) ? 32767 : -32768, 1, 0, "R6");
    sweep("R6");

    // R8: bubbles between samples
    alpha_i = 9'd64; gamma_i = 9'd240;
    for (int i = 0; i < 120; i++)
      step(rnd() % N, rnd() % Z, longint'(rnd() % 201) - 100, (rnd() % 2) == 1, 0, "R8");
    sweep("R8");

    // R9: clear colliding with a valid sample, then first sample writes nothing
    do_clear(1'b1);
    sweep("R9");
    step(2, 3, 500, 1, 0, "R9");
    sweep("R9");
    step(2, 1, 40, 1, 0, "R9");
    sweep("R9");

    // R10: fresh traffic, then confirm whole table
    alpha_i = 9'd192; gamma_i = 9'd128;
    for (int i = 0; i < 100; i++)
      step(rnd() % N, rnd() % Z, longint'(rnd() % 1001) - 500, 1, rnd() % 2, "R10");
    sweep("R10");
    sweep("R2");

    done = 1;
    summary();
    $finish;
  end
endmodule